// File: doc/BRIEF.md
# Bus Read/Write Handshake Sequencer

This block is a clocked controller between a bus master and a slow peripheral. The master asks for a transfer by raising either a read strobe or a write strobe. The controller then runs a four-phase handshake with the peripheral: it drives the device strobe and waits for the device acknowledge. It also drives the enable of the data transceiver and returns a bus acknowledge to the master.

All three inputs pass through a configurable synchroniser before the sequencer looks at them. The three outputs are registered, and at most one of them changes on any clock edge. The read and write cycles use different orders: a read asserts the device strobe before the data enable, and a write asserts the data enable first. Whichever strobe rises while the controller is idle picks the cycle type.

The sequencer tracks the cycle phase in its own state, so two phases that show the same pin levels are still told apart. Any input that changes out of turn sets a sticky protocol error flag. Only reset clears it.

Top module: `bus_hs_ctrl`

## Requirements
- R1: A synchronous active-low reset drives the device strobe, data enable, bus acknowledge and error flag low and returns the controller to idle.
- R2: Each input is seen by the sequencer only after SYNC_STAGES flops. An output responding to an input change therefore updates on the (SYNC_STAGES+1)th clock edge after that change.
- R3: Read cycle order: read strobe high, then device strobe high, then (after the device acknowledge rises) data enable high, then bus acknowledge high one edge later.
- R4: Write cycle order: write strobe high, then data enable high, then device strobe high one edge later. After the device acknowledge rises, data enable goes low, then bus acknowledge goes high one edge later. After the write strobe falls, bus acknowledge goes low, then device strobe goes low one edge later.
- R5: On any clock edge, at most one of the three handshake outputs changes.
- R6: The device strobe never rises while the synchronised device acknowledge is still high from the previous cycle. A new request that arrives during that wait is held until the acknowledge falls, and is then served without a protocol error.
- R7: Read release order: after the read strobe falls, data enable goes low, then bus acknowledge goes low, then device strobe goes low, one edge apart.
- R8: Both strobes high together while idle set the error flag, and no cycle is started.
- R9: Withdrawing the active strobe before the bus acknowledge has risen sets the error flag.
- R10: The device acknowledge falling while the device strobe is still high sets the error flag.
- R11: Once set, the error flag stays high until reset, whatever the inputs do.
- R12: Once a cycle type is chosen, the opposite strobe rising before the bus acknowledge has fallen sets the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req_i | input | 1 | Read strobe from the bus master (asynchronous) |
| wr_req_i | input | 1 | Write strobe from the bus master (asynchronous) |
| dev_ack_i | input | 1 | Acknowledge from the peripheral (asynchronous) |
| dev_stb_o | output | 1 | Strobe to the peripheral |
| xcvr_en_o | output | 1 | Data transceiver enable |
| bus_ack_o | output | 1 | Acknowledge to the bus master |
| proto_err_o | output | 1 | Sticky protocol violation flag |

## Verification
The bench builds the controller with SYNC_STAGES = 2 and computes its sampling points as SYNC_STAGES + 1 edges after each input change. That makes the synchroniser latency (R2) part of every timing check, and every output edge is checked in the exact cycle it is expected. The default depth keeps full read and write cycles short, so one run can cover several patterns:
- the overlap in which a new read request arrives while the previous device acknowledge is still high;
- strobe collisions in idle;
- early strobe withdrawal;
- an early drop of the device acknowledge;
- a late opposite strobe.

// File: rtl/hsc_pkg.sv
// Shared types for the bus handshake sequencer.
// Assumes: one state value per visible handshake phase, plus one release phase.
package hsc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_R_STB  = 4'd1,   // read: device strobe up, waiting for ack
        ST_R_DEN  = 4'd2,   // read: data enable up
        ST_R_ACK  = 4'd3,   // read: bus ack up, waiting for strobe release
        ST_R_DOFF = 4'd4,   // read: data enable dropped
        ST_R_BOFF = 4'd5,   // read: bus ack dropped
        ST_W_DEN  = 4'd6,   // write: data enable up
        ST_W_STB  = 4'd7,   // write: device strobe up, waiting for ack
        ST_W_DOFF = 4'd8,   // write: data enable dropped
        ST_W_ACK  = 4'd9,   // write: bus ack up, waiting for strobe release
        ST_W_BOFF = 4'd10,  // write: bus ack dropped
        ST_REL    = 4'd11   // device strobe low, waiting for ack to fall
    } hs_state_e;

endpackage

// File: rtl/hsc_sync.sv
// Multi-flop synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes: each bit is independent; STAGES >= 2; reset clears every stage.
module hsc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift each bit one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[g] <= '0;
                else if (g == 0)
                    chain[g] <= async_i;
                else
                    chain[g] <= chain[(g > 0) ? g - 1 : 0];
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/hsc_seq.sv
// Handshake sequencer: steps through the read or write phases and drives
// the three registered handshake outputs, changing at most one per edge.
// Assumes: inputs are already synchronised; violations are judged elsewhere.
module hsc_seq
    import hsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_s,
    input  logic      wr_s,
    input  logic      ack_s,
    output hs_state_e state_o,
    output logic      dev_stb_o,
    output logic      xcvr_en_o,
    output logic      bus_ack_o
);
    hs_state_e state;
    logic      stb_q, den_q, back_q;

    // Advance the phase and toggle exactly one output on each phase change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            stb_q  <= 1'b0;
            den_q  <= 1'b0;
            back_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!ack_s && rd_s && !wr_s) begin
                        state <= ST_R_STB;  stb_q <= 1'b1;
                    end else if (!ack_s && wr_s && !rd_s) begin
                        state <= ST_W_DEN;  den_q <= 1'b1;
                    end
                end
                ST_R_STB:  if (ack_s) begin state <= ST_R_DEN;  den_q  <= 1'b1; end
                ST_R_DEN:  begin            state <= ST_R_ACK;  back_q <= 1'b1; end
                ST_R_ACK:  if (!rd_s) begin state <= ST_R_DOFF; den_q  <= 1'b0; end
                ST_R_DOFF: begin            state <= ST_R_BOFF; back_q <= 1'b0; end
                ST_R_BOFF: begin            state <= ST_REL;    stb_q  <= 1'b0; end
                ST_W_DEN:  if (!ack_s) begin state <= ST_W_STB; stb_q  <= 1'b1; end
                ST_W_STB:  if (ack_s) begin state <= ST_W_DOFF; den_q  <= 1'b0; end
                ST_W_DOFF: begin            state <= ST_W_ACK;  back_q <= 1'b1; end
                ST_W_ACK:  if (!wr_s) begin state <= ST_W_BOFF; back_q <= 1'b0; end
                ST_W_BOFF: begin            state <= ST_REL;    stb_q  <= 1'b0; end
                ST_REL:    if (!ack_s)      state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    assign state_o   = state;
    assign dev_stb_o = stb_q;
    assign xcvr_en_o = den_q;
    assign bus_ack_o = back_q;
endmodule

// File: rtl/hsc_viol.sv
// Protocol watchdog: flags any synchronised input level that is illegal in
// the current phase and holds the flag until reset.
// Assumes: the phase comes from hsc_seq and is sampled with the same inputs.
module hsc_viol
    import hsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  hs_state_e state_i,
    input  logic      rd_s,
    input  logic      wr_s,
    input  logic      ack_s,
    output logic      err_o
);
    logic bad;
    logic err_q;

    // Decide whether the present input levels break the phase's rules.
    always_comb begin
        unique case (state_i)
            ST_IDLE:   bad = (rd_s && wr_s) || ack_s;
            ST_R_STB:  bad = !rd_s || wr_s;
            ST_R_DEN:  bad = !rd_s || wr_s || !ack_s;
            ST_R_ACK:  bad = wr_s || !ack_s;
            ST_R_DOFF: bad = rd_s || wr_s || !ack_s;
            ST_R_BOFF: bad = !ack_s;
            ST_W_DEN:  bad = !wr_s || rd_s;
            ST_W_STB:  bad = !wr_s || rd_s;
            ST_W_DOFF: bad = !wr_s || rd_s || !ack_s;
            ST_W_ACK:  bad = rd_s || !ack_s;
            ST_W_BOFF: bad = !ack_s;
            ST_REL:    bad = rd_s && wr_s;
            default:   bad = 1'b1;
        endcase
    end

    // Latch the first violation until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (bad)
            err_q <= 1'b1;
    end

    assign err_o = err_q;
endmodule

// File: rtl/bus_hs_ctrl.sv
// Top of the bus handshake controller: synchronises the three inputs,
// sequences read/write handshakes and reports protocol violations.
// Assumes: rd/wr/ack come from other clock domains; outputs feed glitch-
// sensitive logic, so all of them are flop outputs.
module bus_hs_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req_i,
    input  logic wr_req_i,
    input  logic dev_ack_i,
    output logic dev_stb_o,
    output logic xcvr_en_o,
    output logic bus_ack_o,
    output logic proto_err_o
);
    import hsc_pkg::*;

    localparam int NIN = 3;

    logic [NIN-1:0] sync_v;
    logic           rd_s, wr_s, ack_s;
    hs_state_e      phase;

    hsc_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dev_ack_i, wr_req_i, rd_req_i}),
        .sync_o  (sync_v)
    );

    assign rd_s  = sync_v[0];
    assign wr_s  = sync_v[1];
    assign ack_s = sync_v[2];

    hsc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_s      (rd_s),
        .wr_s      (wr_s),
        .ack_s     (ack_s),
        .state_o   (phase),
        .dev_stb_o (dev_stb_o),
        .xcvr_en_o (xcvr_en_o),
        .bus_ack_o (bus_ack_o)
    );

    hsc_viol u_viol (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (phase),
        .rd_s    (rd_s),
        .wr_s    (wr_s),
        .ack_s   (ack_s),
        .err_o   (proto_err_o)
    );
endmodule

// File: rtl/hsc_chk.sv
// Property checker for bus_hs_ctrl, attached through bind.
// Assumes: ack_s is the synchronised device acknowledge seen by the sequencer.
module hsc_chk (
    input logic clk,
    input logic rst_n,
    input logic stb,
    input logic den,
    input logic back,
    input logic err,
    input logic ack_s
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> ({stb, den, back, err} == 4'b0000));

    // R5
    one_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({stb, den, back} ^ $past({stb, den, back})) <= 1);

    // R3
    ack_after_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(back) |-> ($past(ack_s) && stb));

    // R6
    stb_rise_idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stb) |-> !$past(ack_s));

    // R7
    stb_last_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb) |-> (!back && !den));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err) |-> err);
endmodule

bind bus_hs_ctrl hsc_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (dev_stb_o),
    .den   (xcvr_en_o),
    .back  (bus_ack_o),
    .err   (proto_err_o),
    .ack_s (ack_s)
);

// File: tb/sim_bus_hs_ctrl.sv
`timescale 1ns/1ps
module sim_bus_hs_ctrl;
    localparam int STG = 2;
    localparam int LAT = STG + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd = 1'b0, wr = 1'b0, ack = 1'b0;
    logic stb, den, back, err;
    int   vecs = 0;
    int   fails = 0;
    int   multi_chg = 0;
    logic [2:0] prev_o = 3'b000;

    always #2.5 clk = ~clk;

    bus_hs_ctrl #(.SYNC_STAGES(STG)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_req_i(rd), .wr_req_i(wr),
        .dev_ack_i(ack), .dev_stb_o(stb), .xcvr_en_o(den),
        .bus_ack_o(back), .proto_err_o(err)
    );

    // R5 monitor: count cycles where more than one output moved
    always @(negedge clk) begin
        if (rst_n && $countones({stb, den, back} ^ prev_o) > 1)
            multi_chg++;
        prev_o <= {stb, den, back};
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // exp = {dev_stb, xcvr_en, bus_ack, err}
    task automatic chk(input logic [3:0] exp, input string tag);
        vecs++;
        if ({stb, den, back, err} !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, {stb, den, back, err}, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rd = 0; wr = 0; ack = 0; rst_n = 0;
        step(3);
        rst_n = 1;
    endtask

    task automatic t_read();
        rd = 1; step(LAT - 1); chk(4'b0000, "R2 read strobe latency early");
        step(1);           chk(4'b1000, "R3 device strobe up");
        ack = 1; step(LAT); chk(4'b1100, "R3 data enable after ack");
        step(1);           chk(4'b1110, "R3 bus ack up");
        rd = 0; step(LAT); chk(4'b1010, "R7 data enable off first");
        step(1);           chk(4'b1000, "R7 bus ack off second");
        step(1);           chk(4'b0000, "R7 device strobe off last");
        ack = 0; step(LAT + 1); chk(4'b0000, "R3 read cycle idle");
    endtask

    task automatic t_write();
        wr = 1; step(LAT); chk(4'b0100, "R4 data enable first");
        step(1);           chk(4'b1100, "R4 device strobe second");
        ack = 1; step(LAT); chk(4'b1000, "R4 data enable off after ack");
        step(1);           chk(4'b1010, "R4 bus ack up");
        wr = 0; step(LAT); chk(4'b1000, "R4 bus ack off");
        step(1);           chk(4'b0000, "R4 device strobe off");
        ack = 0; step(LAT + 1); chk(4'b0000, "R4 write cycle idle");
    endtask

    task automatic t_overlap();
        rd = 1; step(LAT); ack = 1; step(LAT + 1); rd = 0; step(LAT + 2);
        chk(4'b0000, "R7 overlap release done");
        rd = 1; step(6);   chk(4'b0000, "R6 no strobe while ack high");
        ack = 0; step(LAT); chk(4'b0000, "R6 still held one edge");
        step(1);           chk(4'b1000, "R6 held request served");
        ack = 1; step(LAT + 1); rd = 0; step(LAT + 2); ack = 0; step(LAT + 1);
        chk(4'b0000, "R6 overlap cycle clean");
    endtask

    task automatic t_both();
        rd = 1; wr = 1; step(LAT); chk(4'b0001, "R8 both strobes idle");
        rd = 0; wr = 0; step(5);   chk(4'b0001, "R11 error held");
        do_reset(); step(1);       chk(4'b0000, "R1 reset clears error");
    endtask

    task automatic t_early_drop();
        rd = 1; step(LAT);  chk(4'b1000, "R9 strobe up");
        rd = 0; step(LAT);  chk(4'b1001, "R9 early withdraw flagged");
        do_reset();
    endtask

    task automatic t_ack_drop();
        rd = 1; step(LAT); ack = 1; step(LAT + 1); chk(4'b1110, "R10 cycle up");
        ack = 0; step(LAT);  chk(4'b1111, "R10 ack fell with strobe high");
        do_reset();
    endtask

    task automatic t_cross();
        rd = 1; step(LAT); ack = 1; step(LAT);
        wr = 1; step(LAT);  chk(4'b1111, "R12 opposite strobe flagged");
        do_reset();
    endtask

    initial begin
        step(1); chk(4'b0000, "R1 outputs low in reset");
        rst_n = 1; step(2); chk(4'b0000, "R1 idle after reset");
        t_read();
        t_write();
        t_overlap();
        t_both();
        t_early_drop();
        t_ack_drop();
        t_cross();
        step(2);
        vecs++;
        if (multi_chg != 0) begin
            fails++;
            $display("FAIL R5: %0d multi-output edges, expected 0", multi_chg);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        #200us;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule